// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller with Memory Start Gate

This block is the test port controller that sits on a chip's serial test pins. It walks the sixteen-state test port graph, one step per rising edge of the test clock, with the mode-select input choosing each step. Through that walk it loads, shifts, pauses and applies a 4-bit instruction register. It does the same for one of two data paths chosen by the instruction: a user data register with a parallel capture port and a parallel update port, or the 1-bit bypass register. Serial data enters least significant bit first on the rising edge and leaves on the falling edge.

The controller has no automatic power-on reset. Its state flops come up undefined. Reset comes either from the asynchronous active-low reset pin or from five rising edges with mode-select held high. A neighbouring memory core has an enable output that stays low until the controller has been reset in one of these two ways. Once it has gone high, the enable never drops again, so the test port always takes priority over normal memory traffic until it has been reset.

Top module: `scan_port_ctrl`

## Requirements
- R1: State changes happen only on the rising edge of `tck`. The level of `tms` on that edge picks the next state along the standard sixteen-state test port graph.
- R2: Five consecutive rising edges with `tms` = 1 bring the controller to Test-Logic-Reset from any state. On the next edge taken in that state, `instr` reads 4'b1111 (BYPASS).
- R3: Driving `trstN` low forces Test-Logic-Reset at once, without a clock edge. While it is low, `instr` = 4'b1111, `updData` = 0, `tdo` = 0 and `tdoEn` = 0.
- R4: `memEnable` goes high on the edge that enters Test-Logic-Reset, or when `trstN` goes low, and stays high from then on. Nothing clears it. The flop has no power-up initialisation.
- R5: On leaving Capture-DR, the user register loads `capData` when `instr` equals the user code 4'b0010. For every other code, the 1-bit bypass register loads 0.
- R6: In Shift-DR and Shift-IR, each rising edge moves the selected register one place toward bit 0 and puts `tdi` into its top bit. `tdo` shows bit 0 and changes only on the falling edge.
- R7: On leaving Update-DR with the user code selected, `updData` takes the shifted contents. In every other state, and under any other code, `updData` holds its value.
- R8: In Pause-DR, Pause-IR and the four exit states, the shift registers keep their contents. A scan that is paused and then resumed gives the same result as one that is not.
- R9: Leaving Capture-IR loads 4'b0001 into the instruction shift register. Leaving Update-IR copies it to `instr`, and `instr` changes at no other time except reset.
- R10: `tdoEn` is high exactly while the controller is in Shift-DR or Shift-IR, and it is updated on the falling edge. At all other times `tdo` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| capData | input | DR_W | Parallel value loaded into the user register on capture |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdoEn | output | 1 | High while `tdo` carries shifted data |
| updData | output | DR_W | Parallel output of the user register, changed only on update |
| instr | output | IR_W | Current instruction |
| memEnable | output | 1 | Allows the attached memory core to operate once the controller has been reset |

## Verification
The user register is scanned with several different capture and shift patterns: 8'hA5 against 8'h3C with a pause after the fourth bit, and 8'h0F against 8'hC3 without a pause. Asymmetric values like these expose a reversed bit order, a lost or extra shift during a pause, and a capture or update that fires on the wrong path. A scan under an unsupported instruction code shows the one-edge delay of the bypass bit, and it leaves `updData` untouched. A run of mode-select ones started in the middle of a shift, and a reset-pin pulse during Shift-DR, separate the synchronous reset path from the asynchronous one.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'hF,
    ST_IDLE     = 4'hC,
    ST_SEL_DR   = 4'h7,
    ST_CAP_DR   = 4'h6,
    ST_SHIFT_DR = 4'h2,
    ST_EX1_DR   = 4'h1,
    ST_PAUSE_DR = 4'h3,
    ST_EX2_DR   = 4'h0,
    ST_UPD_DR   = 4'h5,
    ST_SEL_IR   = 4'h4,
    ST_CAP_IR   = 4'hE,
    ST_SHIFT_IR = 4'hA,
    ST_EX1_IR   = 4'h9,
    ST_PAUSE_IR = 4'hB,
    ST_EX2_IR   = 4'h8,
    ST_UPD_IR   = 4'hD
  } tapState_e;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobe_t;

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapState_e  state,
  output tapStrobe_t strobe,
  output logic       memEnable
);

  tapState_e nextState;
  logic      everReset;

  always_comb begin
    unique case (state)
      ST_RESET:    nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:     nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR:   nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR:   nextState = tms ? ST_EX1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nextState = tms ? ST_EX1_DR : ST_SHIFT_DR;
      ST_EX1_DR:   nextState = tms ? ST_UPD_DR : ST_PAUSE_DR;
      ST_PAUSE_DR: nextState = tms ? ST_EX2_DR : ST_PAUSE_DR;
      ST_EX2_DR:   nextState = tms ? ST_UPD_DR : ST_SHIFT_DR;
      ST_UPD_DR:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR:   nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR:   nextState = tms ? ST_EX1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nextState = tms ? ST_EX1_IR : ST_SHIFT_IR;
      ST_EX1_IR:   nextState = tms ? ST_UPD_IR : ST_PAUSE_IR;
      ST_PAUSE_IR: nextState = tms ? ST_EX2_IR : ST_PAUSE_IR;
      ST_EX2_IR:   nextState = tms ? ST_UPD_IR : ST_SHIFT_IR;
      ST_UPD_IR:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:     nextState = ST_RESET;
    endcase
  end

  // No power-up initialisation: only the pin or the tms sequence resets.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  // Sticky start gate for the memory core; set on entry to reset.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                      everReset <= 1'b1;
    else if (nextState == ST_RESET)  everReset <= 1'b1;
  end

  assign memEnable = everReset;

  always_comb begin
    strobe.inReset   = (state == ST_RESET);
    strobe.captureIr = (state == ST_CAP_IR);
    strobe.shiftIr   = (state == ST_SHIFT_IR);
    strobe.updateIr  = (state == ST_UPD_IR);
    strobe.captureDr = (state == ST_CAP_DR);
    strobe.shiftDr   = (state == ST_SHIFT_DR);
    strobe.updateDr  = (state == ST_UPD_DR);
  end

endmodule

// File: rtl/scan_port_regs.sv
module scan_port_regs
  import scan_port_pkg::*;
#(
  parameter int unsigned IR_W    = 4,
  parameter int unsigned DR_W    = 8,
  parameter int unsigned USER_OP = 2
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  tapStrobe_t      strobe,
  input  logic [DR_W-1:0] capData,
  output logic [DR_W-1:0] updData,
  output logic [IR_W-1:0] instr,
  output logic            tdo,
  output logic            tdoEn
);

  localparam logic [IR_W-1:0] IR_CAPT    = {{(IR_W-1){1'b0}}, 1'b1};
  localparam logic [IR_W-1:0] BYPASS_OP  = {IR_W{1'b1}};
  localparam logic [IR_W-1:0] USER_CODE  = IR_W'(USER_OP);

  logic [IR_W-1:0] irShift;
  logic [DR_W-1:0] drShift;
  logic            bypBit;
  logic            userSel;
  logic            serialBit;
  logic            anyShift;

  assign userSel  = (instr == USER_CODE);
  assign anyShift = strobe.shiftIr | strobe.shiftDr;

  // Instruction shift stage
  always_ff @(posedge tck) begin
    if (strobe.captureIr)    irShift <= IR_CAPT;
    else if (strobe.shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // Applied instruction
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)               instr <= BYPASS_OP;
    else if (strobe.inReset)  instr <= BYPASS_OP;
    else if (strobe.updateIr) instr <= irShift;
  end

  // User data shift stage
  always_ff @(posedge tck) begin
    if (userSel) begin
      if (strobe.captureDr)    drShift <= capData;
      else if (strobe.shiftDr) drShift <= {tdi, drShift[DR_W-1:1]};
    end
  end

  // Bypass bit
  always_ff @(posedge tck) begin
    if (!userSel) begin
      if (strobe.captureDr)    bypBit <= 1'b0;
      else if (strobe.shiftDr) bypBit <= tdi;
    end
  end

  // Parallel update stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                           updData <= '0;
    else if (strobe.updateDr && userSel)  updData <= drShift;
  end

  always_comb begin
    if (strobe.shiftIr)  serialBit = irShift[0];
    else if (userSel)    serialBit = drShift[0];
    else                 serialBit = bypBit;
  end

  // Serial output launched on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= anyShift;
      tdo   <= anyShift & serialBit;
    end
  end

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
#(
  parameter int unsigned IR_W    = 4,
  parameter int unsigned DR_W    = 8,
  parameter int unsigned USER_OP = 2
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tms,
  input  logic            tdi,
  input  logic [DR_W-1:0] capData,
  output logic            tdo,
  output logic            tdoEn,
  output logic [DR_W-1:0] updData,
  output logic [IR_W-1:0] instr,
  output logic            memEnable
);

  tapState_e  tapState;
  tapStrobe_t tapStrobe;

  scan_port_fsm u_fsm (
    .tck       (tck),
    .trstN     (trstN),
    .tms       (tms),
    .state     (tapState),
    .strobe    (tapStrobe),
    .memEnable (memEnable)
  );

  scan_port_regs #(
    .IR_W    (IR_W),
    .DR_W    (DR_W),
    .USER_OP (USER_OP)
  ) u_regs (
    .tck     (tck),
    .trstN   (trstN),
    .tdi     (tdi),
    .strobe  (tapStrobe),
    .capData (capData),
    .updData (updData),
    .instr   (instr),
    .tdo     (tdo),
    .tdoEn   (tdoEn)
  );

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
#(
  parameter int unsigned IR_W = 4,
  parameter int unsigned DR_W = 8
) (
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input tapState_e       state,
  input logic [DR_W-1:0] updData,
  input logic [IR_W-1:0] instr,
  input logic            tdoEn,
  input logic            memEnable
);

  logic [2:0] onesRun;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            onesRun <= 3'd0;
    else if (!tms)         onesRun <= 3'd0;
    else if (onesRun < 3'd5) onesRun <= onesRun + 3'd1;
  end

  // R2: five high mode-select edges land in the reset state
  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!trstN)
    (onesRun == 3'd5) |-> (state == ST_RESET));

  // R4: the memory start gate never drops once raised
  a_r4_enable_sticky: assert property (@(posedge tck) disable iff (!trstN)
    memEnable |=> memEnable);

  // R7: parallel output moves only out of Update-DR
  a_r7_upd_hold: assert property (@(posedge tck) disable iff (!trstN)
    (state != ST_UPD_DR) |=> $stable(updData));

  // R9: instruction moves only out of Update-IR or reset
  a_r9_instr_hold: assert property (@(posedge tck) disable iff (!trstN)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(instr));

  // R10: serial output enable follows the shift states
  a_r10_tdo_enable: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (state == ST_SHIFT_DR || state == ST_SHIFT_IR));

endmodule

bind scan_port_ctrl scan_port_chk #(
  .IR_W (IR_W),
  .DR_W (DR_W)
) u_chk (
  .tck       (tck),
  .trstN     (trstN),
  .tms       (tms),
  .state     (tapState),
  .updData   (updData),
  .instr     (instr),
  .tdoEn     (tdoEn),
  .memEnable (memEnable)
);

// File: tb/scan_port_ctrl_bench.sv
module scan_port_ctrl_bench;

  localparam int CLK_P = 10;
  localparam int IR_W  = 4;
  localparam int DR_W  = 8;
  localparam logic [3:0] USER_C = 4'b0010;

  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4,
                 S_E1DR = 5, S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9,
                 S_CIR = 10, S_SHIR = 11, S_E1IR = 12, S_PIR = 13,
                 S_E2IR = 14, S_UIR = 15;

  logic clk = 1'b0;
  logic trstN, tms, tdi;
  logic [DR_W-1:0] capData;
  logic tdo, tdoEn, memEnable;
  logic [DR_W-1:0] updData;
  logic [IR_W-1:0] instr;

  int checks = 0;
  int fails  = 0;

  int mState;
  logic [3:0] mIr, mIrSh;
  logic [DR_W-1:0] mDr, mUpd;
  logic mByp, mMem;

  always #(CLK_P/2) clk = ~clk;

  scan_port_ctrl #(.IR_W(IR_W), .DR_W(DR_W), .USER_OP(2)) u_scan_port_ctrl (
    .tck(clk), .trstN(trstN), .tms(tms), .tdi(tdi), .capData(capData),
    .tdo(tdo), .tdoEn(tdoEn), .updData(updData), .instr(instr),
    .memEnable(memEnable)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1: behavioural walk of the sixteen-state graph
  function automatic int nextOf(int s, logic m);
    case (s)
      S_TLR:  return m ? S_TLR : S_RTI;
      S_RTI:  return m ? S_SDR : S_RTI;
      S_SDR:  return m ? S_SIR : S_CDR;
      S_CDR, S_SHDR: return m ? S_E1DR : S_SHDR;
      S_E1DR: return m ? S_UDR : S_PDR;
      S_PDR:  return m ? S_E2DR : S_PDR;
      S_E2DR: return m ? S_UDR : S_SHDR;
      S_SIR:  return m ? S_TLR : S_CIR;
      S_CIR, S_SHIR: return m ? S_E1IR : S_SHIR;
      S_E1IR: return m ? S_UIR : S_PIR;
      S_PIR:  return m ? S_E2IR : S_PIR;
      S_E2IR: return m ? S_UIR : S_SHIR;
      default: return m ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic void modelEdge(logic m, logic d);
    bit user = (mIr == USER_C);
    case (mState)
      S_TLR:  mIr = 4'hF;
      S_CIR:  mIrSh = 4'b0001;
      S_SHIR: mIrSh = {d, mIrSh[3:1]};
      S_UIR:  mIr = mIrSh;
      S_CDR:  if (user) mDr = capData; else mByp = 1'b0;
      S_SHDR: if (user) mDr = {d, mDr[DR_W-1:1]}; else mByp = d;
      S_UDR:  if (user) mUpd = mDr;
      default: ;
    endcase
    mState = nextOf(mState, m);
    if (mState == S_TLR) mMem = 1'b1;
  endfunction

  function automatic void modelReset();
    mState = S_TLR; mIr = 4'hF; mUpd = '0; mMem = 1'b1;
  endfunction

  task automatic compareAll();
    logic expEn, expTdo;
    expEn  = (mState == S_SHDR) || (mState == S_SHIR);
    expTdo = 1'b0;
    if (mState == S_SHIR) expTdo = mIrSh[0];
    else if (mState == S_SHDR) expTdo = (mIr == USER_C) ? mDr[0] : mByp;
    chk("R10 tdoEn", 32'(tdoEn), 32'(expEn));
    chk("R6 tdo", 32'(tdo), 32'(expTdo));
    chk("R9 instr", 32'(instr), 32'(mIr));
    chk("R7 updData", 32'(updData), 32'(mUpd));
    chk("R4 memEnable", 32'(memEnable), 32'(mMem));
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge clk);
    modelEdge(m, d);
    @(negedge clk); #1;
    compareAll();
  endtask

  // From Run-Test/Idle: full scan, optional pause after bit pauseAt, back to idle
  task automatic scan(input bit isIr, input int width, input logic [31:0] val,
                      input int pauseAt, output logic [31:0] outVal);
    outVal = '0;
    step(1'b1, 1'b0);
    if (isIr) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < width; i++) begin
      outVal[i] = tdo;
      step((i == width-1) || (i == pauseAt), val[i]);
      if (i == pauseAt && i != width-1) begin
        step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
      end
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] got;
    trstN = 1'b0; tms = 1'b1; tdi = 1'b0; capData = '0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    compareAll();
    trstN = 1'b1;
    chk("R3 reset instr", 32'(instr), 32'hF);
    chk("R4 enable after reset", 32'(memEnable), 32'h1);
    chk("R3 reset tdoEn", 32'(tdoEn), 32'h0);
    step(1'b0, 1'b0);

    scan(1'b1, IR_W, 32'h2, -1, got);
    chk("R9 IR capture pattern", got, 32'h1);
    chk("R9 user code applied", 32'(instr), 32'h2);

    capData = 8'hA5;
    scan(1'b0, DR_W, 32'h3C, 3, got);
    chk("R5 capture via paused scan R8", got, 32'hA5);
    chk("R7 update after paused scan R8", 32'(updData), 32'h3C);

    capData = 8'h0F;
    scan(1'b0, DR_W, 32'hC3, -1, got);
    chk("R5 capture second pattern", got, 32'h0F);
    chk("R7 update second pattern", 32'(updData), 32'hC3);

    scan(1'b1, IR_W, 32'h6, -1, got);
    chk("R9 unsupported code applied", 32'(instr), 32'h6);
    scan(1'b0, DR_W, 32'h96, -1, got);
    chk("R5 bypass one-edge delay", got, 32'h2C);
    chk("R7 bypass leaves updData", 32'(updData), 32'hC3);

    // R2: five ones from the middle of Shift-DR
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b1);
    repeat (5) step(1'b1, 1'b0);
    chk("R2 tdoEn low in reset", 32'(tdoEn), 32'h0);
    step(1'b1, 1'b0);
    chk("R2 instr bypass after five ones", 32'(instr), 32'hF);
    step(1'b0, 1'b0);

    // R3: async reset during Shift-DR
    scan(1'b1, IR_W, 32'h2, -1, got);
    capData = 8'h5A;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b1);
    @(negedge clk); #1;
    trstN = 1'b0;
    modelReset();
    #1;
    compareAll();
    chk("R3 async instr", 32'(instr), 32'hF);
    chk("R3 async tdoEn", 32'(tdoEn), 32'h0);
    chk("R3 async updData", 32'(updData), 32'h0);
    @(negedge clk); #1;
    trstN = 1'b1;
    step(1'b0, 1'b0);

    scan(1'b1, IR_W, 32'h2, -1, got);
    capData = 8'h81;
    scan(1'b0, DR_W, 32'h7E, 5, got);
    chk("R5 capture after reset", got, 32'h81);
    chk("R7 update after reset R8", 32'(updData), 32'h7E);

    finishRun();
  end

endmodule